// File: doc/BRIEF.md
# Parity Bus Transceiver with Latchable Error Flag

This block moves bytes between two buses, called A and B. The A side carries 8 data bits. The B side carries 8 data bits plus one parity bit. The path inverts, so the data leaving each side is the bitwise complement of the data entering the other side.

Each direction has its own active-low output enable:
- **A to B:** the block drives B with the data and a generated odd-parity bit.
- **B to A:** it drives A with the data and checks the incoming 9-bit B word for odd parity.
- **Both enables asserted together:** this is a diagnostic mode. A drives B, but the parity bit is deliberately wrong.
- **Neither enable asserted:** the two buses are isolated.

Tri-state is modelled with separate input, output and drive-enable ports.

The parity-error indication is active low and behaves like an open-drain pin. One output tells when the pin pulls low, and a second output gives the level it reads. A pass control chooses how the flag behaves. With pass high the flag follows the live check. With pass low it holds the value captured at the last clock edge where pass was high. A clear input overrides both settings. The reset input is asserted asynchronously and released in step with the clock.

Top module: `par_xcvr`

## Requirements
- R1: When both `oe_ab_n` and `oe_ba_n` are high, `a_oe` and `b_oe` are both 0.
- R2: When `oe_ab_n`=0 and `oe_ba_n`=1, `b_oe`=1, `a_oe`=0 and `b_out` equals `~a_in` in the same cycle.
- R3: In the mode of R2, the 9-bit word {`b_out`,`b_par_out`} has an odd number of ones.
- R4: When `oe_ba_n`=0 and `oe_ab_n`=1, `a_oe`=1, `b_oe`=0 and `a_out` equals `~b_in` in the same cycle.
- R5: With `pass_en`=1, `clr_n`=1 and B not driven by the block, `err_pull` is 1 exactly when {`b_in`,`b_par_in`} has an even number of ones. `err_n` is always the complement of `err_pull`.
- R6: When both enables are 0, `b_oe`=1, `a_oe`=0, `b_out`=`~a_in`, and {`b_out`,`b_par_out`} has an even number of ones. With `pass_en`=1 and `clr_n`=1, `err_pull` is then 1.
- R7: While `pass_en`=0 and `clr_n`=1, `err_pull` keeps the value captured at the last rising edge where `pass_en` was 1. Changes on `b_in` or `b_par_in` have no effect on it.
- R8: `clr_n`=0 forces `err_pull`=0 at once, whatever `pass_en` is. A rising edge with `clr_n`=0 empties the held flag, so it reads 0 after `clr_n` returns high while `pass_en` stays 0.
- R9: After reset, with `pass_en`=0, `err_pull` is 0 and `err_n` is 1.
- R10: A word produced in the mode of R2 and then fed back on {`b_in`,`b_par_in`} in the mode of R4 gives `err_pull`=0 with `pass_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the error-flag register |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released in step with the clock |
| a_in | input | 8 | Value read from the A bus |
| a_out | output | 8 | Value the block drives onto the A bus |
| a_oe | output | 1 | The block drives the A bus |
| b_in | input | 8 | Data value read from the B bus |
| b_par_in | input | 1 | Parity bit read from the B bus |
| b_out | output | 8 | Data value the block drives onto the B bus |
| b_par_out | output | 1 | Parity bit the block drives onto the B bus |
| b_oe | output | 1 | The block drives the B bus |
| oe_ab_n | input | 1 | Active-low enable for the A-to-B direction |
| oe_ba_n | input | 1 | Active-low enable for the B-to-A direction |
| pass_en | input | 1 | 1: the flag follows the live check; 0: the flag holds its last captured value |
| clr_n | input | 1 | Active-low clear of the error flag |
| err_pull | output | 1 | The open-drain error pin pulls low |
| err_n | output | 1 | Level read on the error pin (0 means error) |

## Verification
All data, enable and parity outputs, and the transparent error flag, are combinational. They are due in the same cycle as the input change. The bench drives inputs on the falling edge and samples 2 ns later, before the next rising edge.

The held flag and the clear only take effect on the register at a rising edge. For these, the bench lets one rising edge pass after the capture or clear stimulus and samples after the following falling edge.

The sweeps cover every A byte and every 9-bit B word in their respective modes.

// File: rtl/par_xcvr_pkg.sv
package par_xcvr_pkg;

  typedef enum logic [1:0] {
    XFER_ISO  = 2'b00,
    XFER_AB   = 2'b01,
    XFER_BA   = 2'b10,
    XFER_DIAG = 2'b11
  } xfer_mode_e;

  typedef struct packed {
    logic drive_a;
    logic drive_b;
    logic flip_par;
  } xfer_ctl_t;

endpackage

// File: rtl/par_xcvr_tree.sv
// XOR reduction built as a ripple of stages; ODD_OUT selects whether the
// output is the plain XOR or the bit that completes odd parity.
module par_xcvr_tree #(
  parameter int W       = 8,
  parameter bit ODD_OUT = 1'b0
) (
  input  logic [W-1:0] din,
  output logic         dout
);

  logic [W-1:0] stage;

  assign stage[0] = din[0];

  generate
    for (genvar i = 1; i < W; i++) begin : g_stage
      assign stage[i] = stage[i-1] ^ din[i];
    end
  endgenerate

  generate
    if (ODD_OUT) begin : g_odd
      assign dout = ~stage[W-1];
    end else begin : g_xor
      assign dout = stage[W-1];
    end
  endgenerate

endmodule

// File: rtl/par_xcvr_mode.sv
// Decodes the two active-low direction enables into drive controls.
module par_xcvr_mode
  import par_xcvr_pkg::*;
(
  input  logic       oe_ab_n,
  input  logic       oe_ba_n,
  output xfer_mode_e mode,
  output xfer_ctl_t  ctl
);

  always_comb begin
    mode = xfer_mode_e'({~oe_ab_n & ~oe_ba_n, 1'b0});
    unique case ({oe_ba_n, oe_ab_n})
      2'b11:   mode = XFER_ISO;
      2'b10:   mode = XFER_AB;
      2'b01:   mode = XFER_BA;
      default: mode = XFER_DIAG;
    endcase
  end

  always_comb begin
    ctl = '0;
    unique case (mode)
      XFER_AB:   ctl.drive_b  = 1'b1;
      XFER_BA:   ctl.drive_a  = 1'b1;
      XFER_DIAG: begin
        ctl.drive_b  = 1'b1;
        ctl.flip_par = 1'b1;
      end
      default:   ctl = '0;
    endcase
  end

endmodule

// File: rtl/par_xcvr_flag.sv
// Error-flag register with transparent pass, hold and priority clear.
module par_xcvr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic live_err,
  input  logic pass_en,
  input  logic clr_n,
  output logic flag
);

  logic held_q;
  logic held_d;
  logic held_en;

  always_comb begin
    held_en = 1'b0;
    held_d  = held_q;
    if (!clr_n) begin
      held_en = 1'b1;
      held_d  = 1'b0;
    end else if (pass_en) begin
      held_en = 1'b1;
      held_d  = live_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
    end else if (held_en) begin
      held_q <= held_d;
    end
  end

  always_comb begin
    if (!clr_n) begin
      flag = 1'b0;
    end else if (pass_en) begin
      flag = live_err;
    end else begin
      flag = held_q;
    end
  end

endmodule

// File: rtl/par_xcvr.sv
module par_xcvr
  import par_xcvr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] a_in,
  output logic [DATA_W-1:0] a_out,
  output logic              a_oe,
  input  logic [DATA_W-1:0] b_in,
  input  logic              b_par_in,
  output logic [DATA_W-1:0] b_out,
  output logic              b_par_out,
  output logic              b_oe,
  input  logic              oe_ab_n,
  input  logic              oe_ba_n,
  input  logic              pass_en,
  input  logic              clr_n,
  output logic              err_pull,
  output logic              err_n
);

  localparam int WORD_W = DATA_W + 1;

  // Reset: asserted at once, released after SYNC_N clock edges.
  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[SYNC_N-1];

  // Direction decode.
  xfer_mode_e mode;
  xfer_ctl_t  ctl;

  par_xcvr_mode u_mode (
    .oe_ab_n (oe_ab_n),
    .oe_ba_n (oe_ba_n),
    .mode    (mode),
    .ctl     (ctl)
  );

  // A-to-B data path and parity generation.
  logic [DATA_W-1:0] a_inv;
  logic              gen_par;

  assign a_inv = ~a_in;

  par_xcvr_tree #(.W(DATA_W), .ODD_OUT(1'b1)) u_gen (
    .din  (a_inv),
    .dout (gen_par)
  );

  assign b_oe      = ctl.drive_b;
  assign b_out     = ctl.drive_b ? a_inv : '0;
  assign b_par_out = ctl.drive_b ? (gen_par ^ ctl.flip_par) : 1'b0;

  // B-to-A data path.
  assign a_oe  = ctl.drive_a;
  assign a_out = ctl.drive_a ? ~b_in : '0;

  // Checker watches the B pins: the driven word when B is driven.
  logic [WORD_W-1:0] chk_word;
  logic              chk_xor;
  logic              live_err;

  assign chk_word = ctl.drive_b ? {b_out, b_par_out} : {b_in, b_par_in};

  par_xcvr_tree #(.W(WORD_W), .ODD_OUT(1'b0)) u_chk_tree (
    .din  (chk_word),
    .dout (chk_xor)
  );

  assign live_err = ~chk_xor;

  // Error flag and open-drain style pin.
  logic flag;

  par_xcvr_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .live_err (live_err),
    .pass_en  (pass_en),
    .clr_n    (clr_n),
    .flag     (flag)
  );

  assign err_pull = flag;
  assign err_n    = ~flag;

  logic mode_unused;
  assign mode_unused = ^mode;

endmodule

// File: rtl/par_xcvr_chk.sv
module par_xcvr_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] a_in,
  input logic [DATA_W-1:0] a_out,
  input logic              a_oe,
  input logic [DATA_W-1:0] b_in,
  input logic [DATA_W-1:0] b_out,
  input logic              b_par_out,
  input logic              b_oe,
  input logic              oe_ab_n,
  input logic              oe_ba_n,
  input logic              pass_en,
  input logic              clr_n,
  input logic              err_pull,
  input logic              err_n
);

  p_iso_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_ab_n && oe_ba_n) |-> (!a_oe && !b_oe));

  p_ab_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_ab_n && oe_ba_n) |-> (b_oe && !a_oe && b_out == ~a_in));

  p_odd_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_ab_n && oe_ba_n) |-> ($countones({b_out, b_par_out}) % 2 == 1));

  p_ba_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_ab_n && !oe_ba_n) |-> (a_oe && !b_oe && a_out == ~b_in));

  p_pin_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_n == !err_pull);

  p_diag_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_ab_n && !oe_ba_n) |-> ($countones({b_out, b_par_out}) % 2 == 0));

  p_diag_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_ab_n && !oe_ba_n && pass_en && clr_n) |-> err_pull);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_en && clr_n && $past(!pass_en && clr_n)) |-> $stable(err_pull));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> !err_pull);

endmodule

bind par_xcvr par_xcvr_chk #(.DATA_W(DATA_W)) u_par_xcvr_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .a_in      (a_in),
  .a_out     (a_out),
  .a_oe      (a_oe),
  .b_in      (b_in),
  .b_out     (b_out),
  .b_par_out (b_par_out),
  .b_oe      (b_oe),
  .oe_ab_n   (oe_ab_n),
  .oe_ba_n   (oe_ba_n),
  .pass_en   (pass_en),
  .clr_n     (clr_n),
  .err_pull  (err_pull),
  .err_n     (err_n)
);

// File: tb/sim_par_xcvr.sv
`timescale 1ns/1ps
module sim_par_xcvr;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] a_in, a_out, b_in, b_out;
  logic       a_oe, b_par_in, b_par_out, b_oe;
  logic       oe_ab_n, oe_ba_n, pass_en, clr_n, err_pull, err_n;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  par_xcvr u0 (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_par_in(b_par_in), .b_out(b_out),
    .b_par_out(b_par_out), .b_oe(b_oe),
    .oe_ab_n(oe_ab_n), .oe_ba_n(oe_ba_n),
    .pass_en(pass_en), .clr_n(clr_n),
    .err_pull(err_pull), .err_n(err_n)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; a_in = '0; b_in = '0; b_par_in = 1'b0;
    oe_ab_n = 1'b1; oe_ba_n = 1'b1; pass_en = 1'b0; clr_n = 1'b1;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R9: held flag empty after reset, even with an erroneous B word present
    b_in = 8'h00; b_par_in = 1'b0;
    #2;
    check("R9 err_pull", err_pull, 0);
    check("R9 err_n", err_n, 1);

    // R1: isolation
    check("R1 a_oe", a_oe, 0);
    check("R1 b_oe", b_oe, 0);

    // R2/R3: sweep all A bytes, A to B
    pass_en = 1'b1;
    oe_ab_n = 1'b0; oe_ba_n = 1'b1;
    for (int v = 0; v < 256; v++) begin
      step();
      a_in = v[7:0];
      #2;
      check("R2 b_out", b_out, ~v[7:0] & 8'hff);
      check("R2 oe", {a_oe, b_oe}, 2'b01);
      check("R3 odd", $countones({b_out, b_par_out}) % 2, 1);
    end

    // R4/R5: sweep all 9-bit B words, B to A
    oe_ab_n = 1'b1; oe_ba_n = 1'b0;
    for (int w = 0; w < 512; w++) begin
      step();
      {b_in, b_par_in} = w[8:0];
      #2;
      check("R4 a_out", a_out, ~w[8:1] & 8'hff);
      check("R4 oe", {a_oe, b_oe}, 2'b10);
      check("R5 err_pull", err_pull, ($countones(w[8:0]) % 2 == 0) ? 1 : 0);
      check("R5 err_n", err_n, ($countones(w[8:0]) % 2 == 0) ? 0 : 1);
    end

    // R5: checker also active with both enables off
    oe_ab_n = 1'b1; oe_ba_n = 1'b1;
    step(); b_in = 8'h01; b_par_in = 1'b1; #2;
    check("R5 iso even", err_pull, 1);
    step(); b_par_in = 1'b0; #2;
    check("R5 iso odd", err_pull, 0);

    // R6: diagnostic mode
    oe_ab_n = 1'b0; oe_ba_n = 1'b0;
    for (int v = 0; v < 256; v++) begin
      step();
      a_in = v[7:0];
      #2;
      check("R6 b_out", b_out, ~v[7:0] & 8'hff);
      check("R6 oe", {a_oe, b_oe}, 2'b01);
      check("R6 even", $countones({b_out, b_par_out}) % 2, 0);
      check("R6 flag", err_pull, 1);
    end

    // R10: loopback of generated words
    for (int v = 0; v < 256; v++) begin
      logic [7:0] cap_d;
      logic       cap_p;
      step();
      oe_ab_n = 1'b0; oe_ba_n = 1'b1; a_in = v[7:0];
      #2;
      cap_d = b_out; cap_p = b_par_out;
      step();
      oe_ab_n = 1'b1; oe_ba_n = 1'b0; b_in = cap_d; b_par_in = cap_p;
      #2;
      check("R10 loopback", err_pull, 0);
    end

    // R7: capture an error, then hold it while B changes
    oe_ab_n = 1'b1; oe_ba_n = 1'b0; pass_en = 1'b1;
    step(); b_in = 8'h03; b_par_in = 1'b0;
    step(); pass_en = 1'b0; b_in = 8'h03; b_par_in = 1'b1;
    #2;
    check("R7 hold err", err_pull, 1);
    step(); b_in = 8'h00; b_par_in = 1'b1; #2;
    check("R7 hold stable", err_pull, 1);
    check("R7 hold pin", err_n, 0);

    // R7: capture a clean result, then hold through an erroneous word
    pass_en = 1'b1; step(); #2;
    step(); pass_en = 1'b0; b_in = 8'h00; b_par_in = 1'b0; #2;
    check("R7 hold clean", err_pull, 0);

    // R8: clear over a held error
    pass_en = 1'b1; step(); #2;
    check("R8 pre live", err_pull, 1);
    step(); pass_en = 1'b0; #2;
    check("R8 pre held", err_pull, 1);
    step(); clr_n = 1'b0; #2;
    check("R8 clear now", err_pull, 0);
    step(); clr_n = 1'b1; #2;
    check("R8 held emptied", err_pull, 0);
    step(); pass_en = 1'b1; clr_n = 1'b0; #2;
    check("R8 clear over pass", err_pull, 0);
    clr_n = 1'b1; #1;
    check("R8 release live", err_pull, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule